// File: doc/BRIEF.md
# Iterative AES Block Cipher Engine

This engine turns one 128-bit block into ciphertext or back into plaintext, using a 128-bit or a 256-bit key. It processes one round in two clock cycles. The round keys are produced alongside the rounds from a window of key words, and that window can step forwards for encryption or backwards for decryption. When a key is loaded, the engine first runs the key schedule through to its end and keeps the final window. A later decryption starts from that stored window.

The host drives plain strobes. It loads a key, loads an initialisation vector, writes a data block, then pulses `start` with the direction and chaining flags. It then waits for `done` and reads `result`. Cipher-block chaining is applied inside the datapath, on the way into the first key addition or on the way out of the last one, so a chained block takes exactly as many cycles as an unchained block. The chaining value updates itself after every chained block until the next vector load.

Top module: `aes_iter_core`

## Requirements
- R1: While reset is low and in the first cycle after it, `busy` and `done` are 0 and `result` is all zeros.
- R2: Encrypting with a 128-bit key gives the standard cipher output. A 128-bit key is presented in `key_data[255:128]`; its first key byte sits at bits [255:248]. Block bytes are big-endian: byte 0 is at bits [127:120].
- R3: Encrypting with a 256-bit key, given whole in `key_data` with byte 0 at [255:248], gives the standard cipher output.
- R4: Decryption (`start_dec`=1) with either key size inverts encryption and returns the original plaintext.
- R5: `done` rises exactly 20 clock edges after the edge that accepts `start` for a 128-bit key, and 28 for a 256-bit key. `busy` is high in between.
- R6: In chained encryption (`start_cbc`=1, `start_dec`=0), the block is XORed with the chaining value before the first key addition. The ciphertext then becomes the chaining value.
- R7: In chained decryption, the cipher output is XORed with the chaining value. The incoming ciphertext becomes the next chaining value.
- R8: An `iv_load` while idle replaces the chaining value, whatever earlier blocks left there.
- R9: A block run without chaining (`start_cbc`=0) neither uses nor alters the chaining value.
- R10: While `busy` is high, `key_load`, `iv_load`, `blk_load` and `start` are ignored. The running result, the stored key, the chaining value and the data block are all unaffected.
- R11: A `key_load` accepted while idle keeps `busy` high for 10 cycles (128-bit key) or 13 cycles (256-bit key) while the schedule is run ahead. `start` is ignored in a cycle that also carries `key_load`.
- R12: `done` is never high while `busy` is high. After it rises, `done` stays high and `result` stays constant until the next accepted `start` or `key_load`, which clears `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| key_load | input | 1 | Strobe: take `key_data` and `key_long`, then run the schedule ahead |
| key_long | input | 1 | 1 = 256-bit key, 0 = 128-bit key in the upper half |
| key_data | input | 256 | Key material |
| iv_load | input | 1 | Strobe: set the chaining value to `iv_data` |
| iv_data | input | 128 | Initialisation vector |
| blk_load | input | 1 | Strobe: store `blk_data` as the next input block |
| blk_data | input | 128 | Input block |
| start | input | 1 | Strobe: process the stored block |
| start_dec | input | 1 | With `start`: 1 = decrypt, 0 = encrypt |
| start_cbc | input | 1 | With `start`: 1 = chained, 0 = independent block |
| busy | output | 1 | Key schedule or block in progress |
| done | output | 1 | Result valid, held until the next start or key load |
| result | output | 128 | Processed block |

## Verification
The bench drives published vectors through both key sizes, both directions and both chaining modes. Wrong S-box arithmetic, a wrong byte rotation or a wrong key-word order would each show up as a wrong ciphertext. A backward key step that recovers the wrong words would show up only in decryption.

Chained runs cover the other ordering faults. Two consecutive blocks show whether the chaining value is updated at all. A fresh vector load after a decryption run shows whether that load really restarts the chain. An unchained block placed between chained blocks shows any leak into the chaining register.

Strobes pulsed in mid-run with garbage key, vector and data must leave the run and the blocks that follow unchanged. Counting cycles from start to done catches an off-by-one in the round or key-step control.

// File: rtl/aes_iter_pkg.sv
// Shared constants, state type and GF(2^8) helpers for the iterative AES engine.
// Assumes big-endian byte order in blocks and 32-bit words (byte 0 at the top).
package aes_iter_pkg;

    localparam int BLK_W  = 128;
    localparam int KEY_W  = 256;
    localparam int WRD_W  = 32;
    localparam int RND_W  = 4;
    localparam logic [RND_W-1:0] NR_SHORT = 4'd10;
    localparam logic [RND_W-1:0] NR_LONG  = 4'd14;

    typedef enum logic [1:0] {ST_IDLE, ST_PREP, ST_RUN} core_st_e;

    // multiply by x modulo the field polynomial
    function automatic logic [7:0] xt(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    // general field multiply
    function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p;
        logic [7:0] x;
        p = 8'h00;
        x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p = p ^ x;
            x = xt(x);
        end
        return p;
    endfunction

    // multiplicative inverse as a^254 (zero maps to zero)
    function automatic logic [7:0] ginv(input logic [7:0] a);
        logic [7:0] p;
        logic [7:0] r;
        p = a;
        r = 8'h01;
        for (int i = 1; i < 8; i++) begin
            p = gmul(p, p);
            r = gmul(r, p);
        end
        return r;
    endfunction

    // rotate a byte left by n
    function automatic logic [7:0] rl(input logic [7:0] x, input int n);
        logic [15:0] d;
        d = {8'h00, x} << n;
        return d[7:0] | d[15:8];
    endfunction

    // forward or inverse substitution sharing one inverter
    function automatic logic [7:0] sbox(input logic [7:0] x, input logic inv);
        logic [7:0] y;
        logic [7:0] z;
        y = inv ? (rl(x, 1) ^ rl(x, 3) ^ rl(x, 6) ^ 8'h05) : x;
        z = ginv(y);
        return inv ? z : (z ^ rl(z, 1) ^ rl(z, 2) ^ rl(z, 3) ^ rl(z, 4) ^ 8'h63);
    endfunction

    // forward substitution of each byte of a word
    function automatic logic [WRD_W-1:0] subword(input logic [WRD_W-1:0] w);
        return {sbox(w[31:24], 1'b0), sbox(w[23:16], 1'b0),
                sbox(w[15:8], 1'b0), sbox(w[7:0], 1'b0)};
    endfunction

    // round constant for index n (1-based)
    function automatic logic [7:0] rcon(input logic [RND_W-1:0] n);
        logic [7:0] r;
        r = 8'h01;
        for (int i = 2; i <= 10; i++) begin
            if (i <= int'(n)) r = xt(r);
        end
        return r;
    endfunction

    // column mix, forward or inverse
    function automatic logic [WRD_W-1:0] mixcol(input logic [WRD_W-1:0] c, input logic inv);
        logic [7:0] a [4];
        logic [7:0] cf [4];
        logic [7:0] b;
        logic [WRD_W-1:0] o;
        for (int k = 0; k < 4; k++) a[k] = c[31-8*k -: 8];
        if (inv) begin
            cf[0] = 8'd14; cf[1] = 8'd11; cf[2] = 8'd13; cf[3] = 8'd9;
        end else begin
            cf[0] = 8'd2;  cf[1] = 8'd3;  cf[2] = 8'd1;  cf[3] = 8'd1;
        end
        o = '0;
        for (int j = 0; j < 4; j++) begin
            b = 8'h00;
            for (int k = 0; k < 4; k++) b = b ^ gmul(a[k], cf[(k - j) & 3]);
            o[31-8*j -: 8] = b;
        end
        return o;
    endfunction

endpackage

// File: rtl/aes_iter_keystep.sv
// One step of the round-key window, forwards or backwards.
// Window layout: [255:128] older block, [127:0] newest block; with a 128-bit key
// only the newest half is used. blk_idx is the index of the newest block.
// A forward step produces block blk_idx+1; a backward step undoes block blk_idx.
module aes_iter_keystep
    import aes_iter_pkg::*;
(
    input  logic [KEY_W-1:0] win,
    input  logic             long_key,
    input  logic             inv,
    input  logic [RND_W-1:0] blk_idx,
    output logic [KEY_W-1:0] nxt
);
    logic [RND_W-1:0] blk;
    logic [RND_W-1:0] rc_idx;
    logic             full;
    logic [WRD_W-1:0] n0, n1, n2, n3, o0, o1, o2, o3;
    logic [WRD_W-1:0] gin, gout;
    logic [WRD_W-1:0] s0, s1, s2, s3;
    logic [WRD_W-1:0] f0, f1, f2, f3;
    logic [WRD_W-1:0] x0, x1, x2, x3;

    // split the window and pick the schedule word type of the touched block
    always_comb begin
        {o0, o1, o2, o3, n0, n1, n2, n3} = win;
        blk    = inv ? blk_idx : blk_idx + 4'd1;
        full   = !long_key || !blk[0];
        rc_idx = long_key ? {1'b0, blk[RND_W-1:1]} : blk;
    end

    // one shared nonlinear word transform for both directions
    always_comb begin
        if (!inv)          gin = n3;
        else if (long_key) gin = o3;
        else               gin = n3 ^ n2;
        gout = full ? (subword({gin[23:0], gin[31:24]}) ^ {rcon(rc_idx), 24'h0})
                    : subword(gin);
    end

    // forward recurrence and backward recovery
    always_comb begin
        {s0, s1, s2, s3} = long_key ? {o0, o1, o2, o3} : {n0, n1, n2, n3};
        f0 = s0 ^ gout;
        f1 = s1 ^ f0;
        f2 = s2 ^ f1;
        f3 = s3 ^ f2;
        x0 = n0 ^ gout;
        x1 = n1 ^ n0;
        x2 = n2 ^ n1;
        x3 = n3 ^ n2;
        if (!inv)          nxt = long_key ? {n0, n1, n2, n3, f0, f1, f2, f3} : {128'h0, f0, f1, f2, f3};
        else if (long_key) nxt = {x0, x1, x2, x3, o0, o1, o2, o3};
        else               nxt = {128'h0, x0, x1, x2, x3};
    end
endmodule

// File: rtl/aes_iter_round.sv
// Combinational halves of one cipher round.
// sub_o: byte substitution with row shift (forward or inverse).
// mix_o: encrypt = column mix (skipped when last) then key add;
//        decrypt = key add then inverse column mix (skipped when last).
module aes_iter_round
    import aes_iter_pkg::*;
(
    input  logic [BLK_W-1:0] st,
    input  logic             dec,
    input  logic             last,
    input  logic [BLK_W-1:0] rk,
    output logic [BLK_W-1:0] sub_o,
    output logic [BLK_W-1:0] mix_o
);
    localparam int NBYTE = BLK_W / 8;
    localparam int NCOL  = BLK_W / WRD_W;

    for (genvar i = 0; i < NBYTE; i++) begin : g_byte
        localparam int C  = i / 4;
        localparam int R  = i % 4;
        localparam int CE = (C + R) % 4;
        localparam int CD = (C + 4 - R) % 4;
        logic [7:0] be, bd;
        // fetch the row-shifted source byte for either direction
        assign be = st[BLK_W-1-8*(4*CE+R) -: 8];
        assign bd = st[BLK_W-1-8*(4*CD+R) -: 8];
        assign sub_o[BLK_W-1-8*i -: 8] = sbox(dec ? bd : be, dec);
    end

    for (genvar j = 0; j < NCOL; j++) begin : g_col
        logic [WRD_W-1:0] col, rkc, te, td;
        // column mix and key addition in direction order
        assign col = st[BLK_W-1-WRD_W*j -: WRD_W];
        assign rkc = rk[BLK_W-1-WRD_W*j -: WRD_W];
        assign te  = (last ? col : mixcol(col, 1'b0)) ^ rkc;
        assign td  = col ^ rkc;
        assign mix_o[BLK_W-1-WRD_W*j -: WRD_W] = dec ? (last ? td : mixcol(td, 1'b1)) : te;
    end
endmodule

// File: rtl/aes_iter_core.sv
// Iterative AES engine for 128/256-bit keys, both directions, optional chaining.
// Two cycles per round: substitute/shift, then mix/key-add. Round keys are made
// on the fly; a key load runs the schedule ahead once so decryption can walk it
// backwards. Strobes are honoured only while idle. Synchronous active-low reset.
module aes_iter_core
    import aes_iter_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_load,
    input  logic             key_long,
    input  logic [KEY_W-1:0] key_data,
    input  logic             iv_load,
    input  logic [BLK_W-1:0] iv_data,
    input  logic             blk_load,
    input  logic [BLK_W-1:0] blk_data,
    input  logic             start,
    input  logic             start_dec,
    input  logic             start_cbc,
    output logic             busy,
    output logic             done,
    output logic [BLK_W-1:0] result
);
    core_st_e         fsm_q;
    logic [KEY_W-1:0] key_q, cache_q, win_q, win_nx;
    logic [BLK_W-1:0] chain_q, blk_q, st_q, res_q;
    logic [BLK_W-1:0] sub_o, mix_o, rk, fin_out;
    logic [RND_W-1:0] bidx_q, rnd_q, nr;
    logic             long_q, dec_q, cbc_q, ph_q, done_q;
    logic             last, do_step, ks_inv;

    // round count, key selection and step decision for the current round
    always_comb begin
        nr      = long_q ? NR_LONG : NR_SHORT;
        ks_inv  = (fsm_q == ST_RUN) && dec_q;
        last    = dec_q ? (rnd_q == '0) : (rnd_q == nr);
        rk      = (bidx_q == rnd_q) ? win_q[BLK_W-1:0] : win_q[KEY_W-1:BLK_W];
        do_step = dec_q ? ({1'b0, bidx_q} > ({1'b0, rnd_q} + {4'b0, long_q}))
                        : (bidx_q < rnd_q);
        fin_out = (dec_q && cbc_q) ? (mix_o ^ chain_q) : mix_o;
    end

    aes_iter_keystep u_kstep (
        .win      (win_q),
        .long_key (long_q),
        .inv      (ks_inv),
        .blk_idx  (bidx_q),
        .nxt      (win_nx)
    );

    aes_iter_round u_round (
        .st    (st_q),
        .dec   (dec_q),
        .last  (last),
        .rk    (rk),
        .sub_o (sub_o),
        .mix_o (mix_o)
    );

    // control sequencing, key window, state and chaining registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q   <= ST_IDLE;
            key_q   <= '0;
            cache_q <= '0;
            win_q   <= '0;
            chain_q <= '0;
            blk_q   <= '0;
            st_q    <= '0;
            res_q   <= '0;
            bidx_q  <= '0;
            rnd_q   <= '0;
            long_q  <= 1'b0;
            dec_q   <= 1'b0;
            cbc_q   <= 1'b0;
            ph_q    <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            case (fsm_q)
                ST_IDLE: begin
                    if (iv_load)  chain_q <= iv_data;
                    if (blk_load) blk_q   <= blk_data;
                    if (key_load) begin
                        key_q  <= key_data;
                        long_q <= key_long;
                        win_q  <= key_long ? key_data : {128'h0, key_data[KEY_W-1:BLK_W]};
                        bidx_q <= {3'b0, key_long};
                        done_q <= 1'b0;
                        fsm_q  <= ST_PREP;
                    end else if (start) begin
                        dec_q  <= start_dec;
                        cbc_q  <= start_cbc;
                        done_q <= 1'b0;
                        ph_q   <= 1'b0;
                        st_q   <= blk_q
                                ^ ((start_cbc && !start_dec) ? chain_q : '0)
                                ^ (start_dec ? cache_q[BLK_W-1:0] : key_q[KEY_W-1:BLK_W]);
                        win_q  <= start_dec ? cache_q
                                : (long_q ? key_q : {128'h0, key_q[KEY_W-1:BLK_W]});
                        bidx_q <= start_dec ? nr : {3'b0, long_q};
                        rnd_q  <= start_dec ? nr - 4'd1 : 4'd1;
                        fsm_q  <= ST_RUN;
                    end
                end
                ST_PREP: begin
                    win_q  <= win_nx;
                    bidx_q <= bidx_q + 4'd1;
                    if (bidx_q + 4'd1 == nr) begin
                        cache_q <= win_nx;
                        fsm_q   <= ST_IDLE;
                    end
                end
                ST_RUN: begin
                    if (!ph_q) begin
                        st_q <= sub_o;
                        ph_q <= 1'b1;
                        if (do_step) begin
                            win_q  <= win_nx;
                            bidx_q <= dec_q ? bidx_q - 4'd1 : bidx_q + 4'd1;
                        end
                    end else if (last) begin
                        res_q  <= fin_out;
                        done_q <= 1'b1;
                        fsm_q  <= ST_IDLE;
                        if (cbc_q) chain_q <= dec_q ? blk_q : fin_out;
                    end else begin
                        st_q  <= mix_o;
                        rnd_q <= dec_q ? rnd_q - 4'd1 : rnd_q + 4'd1;
                        ph_q  <= 1'b0;
                    end
                end
                default: fsm_q <= ST_IDLE;
            endcase
        end
    end

    assign busy   = (fsm_q != ST_IDLE);
    assign done   = done_q;
    assign result = res_q;
endmodule

// File: rtl/aes_iter_core_chk.sv
// Protocol and timing checks for aes_iter_core, attached with bind.
// Tracks the key size and the cycles since an accepted start with its own counter.
module aes_iter_core_chk
    import aes_iter_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             key_load,
    input logic             key_long,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [BLK_W-1:0] result
);
    logic       long_k;
    logic [5:0] cnt;
    logic       go;

    assign go = start && !busy && !key_load;

    // shadow key size and cycles elapsed since start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            long_k <= 1'b0;
            cnt    <= '0;
        end else begin
            if (key_load && !busy) long_k <= key_long;
            if (go)                cnt <= '0;
            else if (busy && cnt != 6'h3f) cnt <= cnt + 6'd1;
        end
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && result == '0));

    a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> cnt == (long_k ? 6'd28 : 6'd20));

    a_r10_result_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(result) || done));

    a_r12_never_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    a_r12_done_held: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start && !key_load) |=> (done && $stable(result)));

    a_r12_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> (busy && !done));
endmodule

bind aes_iter_core aes_iter_core_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_load (key_load),
    .key_long (key_long),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .result   (result)
);

// File: tb/aes_iter_core_tb_top.sv
// Scoreboard bench: driver tasks queue expected blocks, a monitor compares on done.
module aes_iter_core_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         key_load = 1'b0, key_long = 1'b0;
    logic [255:0] key_data = '0;
    logic         iv_load = 1'b0, blk_load = 1'b0;
    logic [127:0] iv_data = '0, blk_data = '0;
    logic         start = 1'b0, start_dec = 1'b0, start_cbc = 1'b0;
    logic         busy, done;
    logic [127:0] result;

    int           n_run = 0, n_fail = 0;
    logic [127:0] exp_q[$];
    string        tag_q[$];
    logic         done_d = 1'b0;
    logic         cur_long = 1'b0;

    always #4 clk = ~clk;

    aes_iter_core dut_i (
        .clk(clk), .rst_n(rst_n), .key_load(key_load), .key_long(key_long),
        .key_data(key_data), .iv_load(iv_load), .iv_data(iv_data),
        .blk_load(blk_load), .blk_data(blk_data), .start(start),
        .start_dec(start_dec), .start_cbc(start_cbc), .busy(busy),
        .done(done), .result(result)
    );

    localparam logic [127:0] IV   = 128'h000102030405060708090a0b0c0d0e0f;
    localparam logic [127:0] P1   = 128'h6bc1bee22e409f96e93d7e117393172a;
    localparam logic [127:0] P2   = 128'hae2d8a571e03ac9c9eb76fac45af8e51;
    localparam logic [127:0] PF   = 128'h00112233445566778899aabbccddeeff;

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: compare each new result with the head of the scoreboard
    always @(negedge clk) begin
        if (rst_n && done && !done_d) begin
            if (exp_q.size() == 0) chk(1'b0, "R12 unexpected done", result, '0);
            else chk(result == exp_q[0], tag_q[0], result, exp_q[0]);
            if (exp_q.size() != 0) begin
                void'(exp_q.pop_front());
                void'(tag_q.pop_front());
            end
        end
        done_d <= done;
    end

    task automatic load_key(input logic [255:0] k, input logic lng, input int exp_busy);
        int n;
        @(negedge clk);
        key_load = 1'b1; key_data = k; key_long = lng;
        @(negedge clk);
        key_load = 1'b0;
        cur_long = lng;
        n = 0;
        while (busy && n < 100) begin
            n++;
            @(negedge clk);
        end
        chk(n == exp_busy, "R11 schedule busy cycles", 128'(n), 128'(exp_busy));
    endtask

    task automatic set_iv(input logic [127:0] v);
        @(negedge clk);
        iv_load = 1'b1; iv_data = v;
        @(negedge clk);
        iv_load = 1'b0;
    endtask

    task automatic run_blk(input logic [127:0] d, input bit ld, input bit dec, input bit cbc,
                           input logic [127:0] e, input string tag, input bit noise);
        int n;
        if (ld) begin
            @(negedge clk);
            blk_load = 1'b1; blk_data = d;
        end
        @(negedge clk);
        blk_load = 1'b0;
        start = 1'b1; start_dec = dec; start_cbc = cbc;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        start = 1'b0;
        n = 1;
        while (!done && n < 100) begin
            if (noise && n == 3) begin
                key_load = 1'b1; key_long = 1'b1; key_data = '1;
                iv_load = 1'b1; iv_data = '1; blk_load = 1'b1; blk_data = '1;
                start = 1'b1; start_dec = ~dec;
            end else begin
                key_load = 1'b0; iv_load = 1'b0; blk_load = 1'b0; start = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        key_load = 1'b0; iv_load = 1'b0; blk_load = 1'b0; start = 1'b0;
        chk(n == (cur_long ? 29 : 21), "R5 start-to-done cycles", 128'(n), 128'(cur_long ? 29 : 21));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 128'(0), 128'(1));
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [127:0] hold;
        repeat (3) @(negedge clk);
        chk(!busy && !done && result == '0, "R1 reset state", {busy, done, result[125:0]}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && result == '0, "R1 after reset", {busy, done, result[125:0]}, '0);

        // standard single-block vectors, 128-bit key in the upper half
        load_key({128'h000102030405060708090a0b0c0d0e0f, 128'h0}, 1'b0, 10);
        run_blk(PF, 1, 0, 0, 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R2 encrypt 128", 0);
        run_blk(128'h69c4e0d86a7b0430d8cdb78070b4c55a, 1, 1, 0, PF, "R4 decrypt 128", 0);

        load_key(256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f, 1'b1, 13);
        run_blk(PF, 1, 0, 0, 128'h8ea2b7ca516745bfeafc49904b496089, "R3 encrypt 256", 0);
        run_blk(128'h8ea2b7ca516745bfeafc49904b496089, 1, 1, 0, PF, "R4 decrypt 256", 0);

        // chained mode, 128-bit key
        load_key({128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h0}, 1'b0, 10);
        set_iv(IV);
        run_blk(P1, 1, 0, 1, 128'h7649abac8119b246cee98e9b12e9197d, "R6 chained enc blk1", 0);
        run_blk(P2, 1, 0, 1, 128'h5086cb9b507219ee95db113a917678b2, "R6 chained enc blk2", 0);
        set_iv(IV);
        run_blk(128'h7649abac8119b246cee98e9b12e9197d, 1, 1, 1, P1, "R7 chained dec blk1", 0);
        run_blk(128'h5086cb9b507219ee95db113a917678b2, 1, 1, 1, P2, "R7 chained dec blk2", 0);
        set_iv(IV);
        run_blk(P1, 1, 0, 1, 128'h7649abac8119b246cee98e9b12e9197d, "R8 vector reload R10 mid-run strobes", 1);
        run_blk(P1, 0, 0, 0, 128'h3ad77bb40d7a3660a89ecaf32466ef97, "R9 independent block R10 data kept", 0);
        run_blk(P2, 1, 0, 1, 128'h5086cb9b507219ee95db113a917678b2, "R9 chain untouched R10 key and vector kept", 0);

        // held result
        hold = result;
        repeat (6) @(negedge clk);
        chk(done && result == hold, "R12 done and result held", result, hold);

        // chained mode, 256-bit key
        load_key(256'h603deb1015ca71be2b73aef0857d77811f352c073b6108d72d9810a30914dff4, 1'b1, 13);
        chk(!done, "R12 key load clears done", 128'(done), 128'(0));
        set_iv(IV);
        run_blk(P1, 1, 0, 1, 128'hf58c4c04d6e5f1ba779eabfb5f7bfbd6, "R6 chained enc 256 blk1", 0);
        run_blk(P2, 1, 0, 1, 128'h9cfc4e967edb808d679f777bc6702c7d, "R6 chained enc 256 blk2", 0);
        set_iv(IV);
        run_blk(128'hf58c4c04d6e5f1ba779eabfb5f7bfbd6, 1, 1, 1, P1, "R7 chained dec 256 blk1", 0);
        run_blk(128'h9cfc4e967edb808d679f777bc6702c7d, 1, 1, 1, P2, "R7 chained dec 256 blk2", 0);

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R12 every queued block produced", 128'(exp_q.size()), '0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule